// File: doc/BRIEF.md
# In-Order Retirement Queue

This block keeps the program order of instructions that execute out of order. Each instruction that leaves the issue stage takes the next slot of a circular queue. The slot holds the instruction's rename-buffer tag, its architectural destination register and a flag that says whether it has finished. The queue returns the slot index it assigned, and it raises full and empty flags.

Execution units report a finished instruction by its rename-buffer tag and not by its slot index. Every occupied slot compares the reported tag with its own tag in parallel, and the slot that matches is marked finished. Instructions usually finish out of order because their latencies differ.

Retirement happens only at the oldest slot. In each cycle the two oldest slots may retire, and the younger one only together with the older one. Each retirement shows its tag and destination on a commit port, so the rename logic can write the architectural register and free the buffer. The slot is then free again. A flush discards every entry at once.

Top module: `rob_inorder`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0), `alloc_idx` is 0 and neither commit slot is valid.
- R2: An accepted issue (`iss_valid`=1 while `full`=0 and `flush`=0) writes the slot at `alloc_idx`, and `alloc_idx` advances by one modulo DEPTH at the next edge.
- R3: After DEPTH accepted issues with no retirement, `full`=1. An issue while full is dropped: `alloc_idx` holds, and the entry never appears on the commit ports.
- R4: A finish report marks only an occupied, unfinished slot whose stored tag equals `fin_tag`. A tag that no slot holds has no effect.
- R5: A commit is reported only for the oldest slot, and only once it has finished. A finished younger slot waits while any older slot is unfinished.
- R6: Commit slot 1 (the second-oldest entry) is valid only in a cycle where commit slot 0 (the oldest entry) is also valid. Both are valid when the two oldest entries have both finished.
- R7: Each commit slot presents the tag and architectural destination that were written at issue, and entries retire in issue order.
- R8: A retired slot is released at the next edge. `full` drops, the freed slots are allocated again in wrapped order, and the queue reads empty once every entry has retired.
- R9: `flush` suppresses both commit slots in the same cycle and drops any issue in that cycle. At the next edge the queue is empty and `alloc_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all entries |
| iss_valid | input | 1 | Issue request |
| iss_tag | input | TAG_W | Rename-buffer tag of the issued instruction |
| iss_areg | input | AREG_W | Architectural destination register |
| alloc_idx | output | log2(DEPTH) | Slot taken by an issue this cycle |
| full | output | 1 | No free slot; issue is refused |
| empty | output | 1 | No occupied slot |
| fin_valid | input | 1 | Finish report valid |
| fin_tag | input | TAG_W | Rename-buffer tag of the finished instruction |
| cmt0_valid | output | 1 | Oldest entry retires this cycle |
| cmt0_tag | output | TAG_W | Tag of the oldest retiring entry |
| cmt0_areg | output | AREG_W | Destination of the oldest retiring entry |
| cmt1_valid | output | 1 | Second-oldest entry retires this cycle |
| cmt1_tag | output | TAG_W | Tag of the second retiring entry |
| cmt1_areg | output | AREG_W | Destination of the second retiring entry |

## Verification
The properties assume that the tags of occupied slots are unique, so a finish report matches at most one slot. They also assume that a finish report names an instruction already written into the queue. The stimulus issues distinct tags, and a tag is reused only after its earlier owner has retired or been flushed. Every finish report in the stimulus either names an instruction already in the queue or is an intentionally foreign tag that tests R4.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Number of entries that leave the head in one cycle.
    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_ONE  = 2'd1,
        RET_TWO  = 2'd2
    } ret_cnt_e;

    function automatic ret_cnt_e ret_count(input logic take0, input logic take1);
        if (take0 && take1) return RET_TWO;
        if (take0)          return RET_ONE;
        return RET_NONE;
    endfunction

endpackage

// File: rtl/rob_tag_match.sv
module rob_tag_match #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 4
) (
    input  logic [DEPTH-1:0]            slot_vld,
    input  logic [DEPTH-1:0]            slot_done,
    input  logic [DEPTH-1:0][TAG_W-1:0] slot_tag,
    input  logic                        rpt_valid,
    input  logic [TAG_W-1:0]            rpt_tag,
    output logic [DEPTH-1:0]            hit
);

    // One comparator per slot; only occupied, still-pending slots can hit.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = rpt_valid && slot_vld[g] && !slot_done[g]
                        && (slot_tag[g] == rpt_tag);
    end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] slot_vld,
    input  logic [DEPTH-1:0] slot_done,
    input  logic [IDX_W-1:0] head_idx,
    input  logic             hold,
    output logic             take0,
    output logic             take1,
    output logic [IDX_W-1:0] idx0,
    output logic [IDX_W-1:0] idx1,
    output rob_pkg::ret_cnt_e cnt
);

    always_comb begin
        idx0  = head_idx;
        idx1  = head_idx + IDX_W'(1);
        take0 = !hold && slot_vld[idx0] && slot_done[idx0];
        take1 = take0 && slot_vld[idx1] && slot_done[idx1];
        cnt   = rob_pkg::ret_count(take0, take1);
    end

endmodule

// File: rtl/rob_inorder.sv
module rob_inorder #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 4,
    parameter int AREG_W = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [AREG_W-1:0] iss_areg,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              full,
    output logic              empty,
    input  logic              fin_valid,
    input  logic [TAG_W-1:0]  fin_tag,
    output logic              cmt0_valid,
    output logic [TAG_W-1:0]  cmt0_tag,
    output logic [AREG_W-1:0] cmt0_areg,
    output logic              cmt1_valid,
    output logic [TAG_W-1:0]  cmt1_tag,
    output logic [AREG_W-1:0] cmt1_areg
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0]             done;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][AREG_W-1:0] areg;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
    } rob_state_t;

    rob_state_t s_d, s_q;

    logic [DEPTH-1:0]  hit;
    logic              take0, take1;
    logic [IDX_W-1:0]  idx0, idx1;
    rob_pkg::ret_cnt_e ret_cnt;
    logic [IDX_W-1:0]  head_idx, tail_idx;
    logic              accept;

    assign head_idx = s_q.head[IDX_W-1:0];
    assign tail_idx = s_q.tail[IDX_W-1:0];

    // The wrap bit tells a full queue from an empty one.
    assign empty = (s_q.head == s_q.tail);
    assign full  = (head_idx == tail_idx) && (s_q.head[IDX_W] != s_q.tail[IDX_W]);
    assign alloc_idx = tail_idx;
    assign accept = iss_valid && !full && !flush;

    rob_tag_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
        .slot_vld  (s_q.vld),
        .slot_done (s_q.done),
        .slot_tag  (s_q.tag),
        .rpt_valid (fin_valid),
        .rpt_tag   (fin_tag),
        .hit       (hit)
    );

    rob_retire_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_sel (
        .slot_vld  (s_q.vld),
        .slot_done (s_q.done),
        .head_idx  (head_idx),
        .hold      (flush),
        .take0     (take0),
        .take1     (take1),
        .idx0      (idx0),
        .idx1      (idx1),
        .cnt       (ret_cnt)
    );

    assign cmt0_valid = take0;
    assign cmt0_tag   = s_q.tag[idx0];
    assign cmt0_areg  = s_q.areg[idx0];
    assign cmt1_valid = take1;
    assign cmt1_tag   = s_q.tag[idx1];
    assign cmt1_areg  = s_q.areg[idx1];

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.vld  = '0;
            s_d.done = '0;
            s_d.head = '0;
            s_d.tail = '0;
        end else begin
            s_d.done = s_q.done | hit;
            if (take0) begin
                s_d.vld[idx0]  = 1'b0;
                s_d.done[idx0] = 1'b0;
            end
            if (take1) begin
                s_d.vld[idx1]  = 1'b0;
                s_d.done[idx1] = 1'b0;
            end
            s_d.head = s_q.head + PTR_W'(ret_cnt);
            if (accept) begin
                s_d.vld[tail_idx]  = 1'b1;
                s_d.done[tail_idx] = 1'b0;
                s_d.tag[tail_idx]  = iss_tag;
                s_d.areg[tail_idx] = iss_areg;
                s_d.tail           = s_q.tail + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/rob_inorder_chk.sv
module rob_inorder_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             iss_valid,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             full,
    input logic             empty,
    input logic             cmt0_valid,
    input logic             cmt1_valid
);

    p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && iss_valid && !flush) |=> (alloc_idx == $past(alloc_idx)));

    p_issue_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !full && !flush) |=> (alloc_idx == IDX_W'($past(alloc_idx) + 1'b1)));

    p_empty_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !cmt0_valid);

    p_pair_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmt1_valid |-> cmt0_valid);

    p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && alloc_idx == '0));

    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !cmt0_valid);

endmodule

bind rob_inorder rob_inorder_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .iss_valid  (iss_valid),
    .alloc_idx  (alloc_idx),
    .full       (full),
    .empty      (empty),
    .cmt0_valid (cmt0_valid),
    .cmt1_valid (cmt1_valid)
);

// File: tb/rob_inorder_test.sv
`timescale 1ns/1ps
module rob_inorder_test;

    localparam int DEPTH = 8;
    localparam int TAG_W = 4;
    localparam int AREG_W = 5;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic iss_valid = 1'b0;
    logic [TAG_W-1:0] iss_tag = '0;
    logic [AREG_W-1:0] iss_areg = '0;
    logic fin_valid = 1'b0;
    logic [TAG_W-1:0] fin_tag = '0;
    logic [IDX_W-1:0] alloc_idx;
    logic full, empty;
    logic cmt0_valid, cmt1_valid;
    logic [TAG_W-1:0] cmt0_tag, cmt1_tag;
    logic [AREG_W-1:0] cmt0_areg, cmt1_areg;

    always #2 clk = ~clk;

    rob_inorder uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_areg(iss_areg),
        .alloc_idx(alloc_idx), .full(full), .empty(empty),
        .fin_valid(fin_valid), .fin_tag(fin_tag),
        .cmt0_valid(cmt0_valid), .cmt0_tag(cmt0_tag), .cmt0_areg(cmt0_areg),
        .cmt1_valid(cmt1_valid), .cmt1_tag(cmt1_tag), .cmt1_areg(cmt1_areg)
    );

    int vec = 0;
    int bad = 0;
    int exp_tag [0:31];
    int exp_areg[0:31];
    int wr = 0;
    int rd = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input int t, input int a);
        exp_tag[wr]  = t;
        exp_areg[wr] = a;
        wr++;
    endtask

    // Compare the visible commits with the expected program order (R7).
    task automatic observe();
        if (cmt1_valid && !cmt0_valid) check("R6", "slot1 without slot0", 1, 0);
        if (cmt0_valid) begin
            if (rd < wr) begin
                check("R7", "slot0 tag", int'(cmt0_tag), exp_tag[rd]);
                check("R7", "slot0 areg", int'(cmt0_areg), exp_areg[rd]);
            end else check("R3", "commit beyond issued entries", 1, 0);
            rd++;
        end
        if (cmt1_valid) begin
            if (rd < wr) begin
                check("R7", "slot1 tag", int'(cmt1_tag), exp_tag[rd]);
                check("R7", "slot1 areg", int'(cmt1_areg), exp_areg[rd]);
            end else check("R3", "commit beyond issued entries", 1, 0);
            rd++;
        end
    endtask

    task automatic step();
        @(negedge clk);
        observe();
    endtask

    task automatic idle();
        iss_valid = 1'b0;
        fin_valid = 1'b0;
        flush     = 1'b0;
    endtask

    task automatic drive_issue(input int t, input int a);
        iss_valid = 1'b1;
        iss_tag   = TAG_W'(t);
        iss_areg  = AREG_W'(a);
    endtask

    task automatic drive_fin(input int t);
        fin_valid = 1'b1;
        fin_tag   = TAG_W'(t);
    endtask

    task automatic t_reset();
        step();
        check("R1", "empty", int'(empty), 1);
        check("R1", "full", int'(full), 0);
        check("R1", "alloc_idx", int'(alloc_idx), 0);
        check("R1", "cmt0_valid", int'(cmt0_valid), 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) begin
            check("R2", "alloc_idx during fill", int'(alloc_idx), i);
            drive_issue(i, 10 + i);
            push_exp(i, 10 + i);
            step();
            idle();
        end
        check("R3", "full after fill", int'(full), 1);
        check("R3", "not empty after fill", int'(empty), 0);
        drive_issue(15, 31);
        step();
        idle();
        check("R3", "full holds", int'(full), 1);
        check("R3", "alloc_idx holds", int'(alloc_idx), 0);
    endtask

    task automatic t_out_of_order();
        drive_fin(3);
        step(); idle();
        check("R5", "younger finished, head pending", int'(cmt0_valid), 0);
        drive_fin(12);
        step(); idle();
        check("R4", "foreign tag ignored", int'(cmt0_valid), 0);
        drive_fin(0);
        step(); idle();
        check("R6", "single head commit slot0", int'(cmt0_valid), 1);
        check("R6", "single head commit slot1", int'(cmt1_valid), 0);
        drive_fin(1);
        step(); idle();
        check("R5", "entry1 at head", int'(cmt0_valid), 1);
        check("R5", "entry2 pending blocks", int'(cmt1_valid), 0);
        step();
        check("R5", "head pending blocks finished entry3", int'(cmt0_valid), 0);
        drive_fin(2);
        step(); idle();
        check("R6", "pair slot0", int'(cmt0_valid), 1);
        check("R6", "pair slot1", int'(cmt1_valid), 1);
        step();
        check("R8", "full cleared after retire", int'(full), 0);
        check("R8", "alloc_idx wraps to 0", int'(alloc_idx), 0);
        drive_issue(8, 20); push_exp(8, 20);
        step(); idle();
        check("R8", "alloc_idx after reuse", int'(alloc_idx), 1);
        drive_issue(9, 21); push_exp(9, 21);
        step(); idle();
        drive_fin(9); step(); idle();
        drive_fin(8); step(); idle();
        drive_fin(7); step(); idle();
        drive_fin(6); step(); idle();
        drive_fin(5); step(); idle();
        drive_fin(4); step(); idle();
        for (int k = 0; k < 6; k++) step();
        check("R8", "empty after drain", int'(empty), 1);
        check("R3", "commit count equals accepted issues", rd, wr);
    endtask

    task automatic t_flush();
        drive_issue(1, 1); step(); idle();
        drive_issue(2, 2); step(); idle();
        drive_issue(3, 3); step(); idle();
        check("R9", "entries present before flush", int'(empty), 0);
        flush = 1'b1;
        drive_issue(4, 4);
        step(); idle();
        check("R9", "empty after flush", int'(empty), 1);
        check("R9", "alloc_idx after flush", int'(alloc_idx), 0);
        check("R9", "full after flush", int'(full), 0);
        drive_issue(5, 7); push_exp(5, 7);
        step(); idle();
        drive_fin(5);
        step(); idle();
        flush = 1'b1;
        #1;
        check("R9", "flush suppresses commit", int'(cmt0_valid), 0);
        step(); idle();
        check("R9", "empty after second flush", int'(empty), 1);
        check("R2", "alloc_idx before reissue", int'(alloc_idx), 0);
        drive_issue(6, 9); push_exp(6, 9);
        step(); idle();
        drive_fin(6);
        step(); idle();
        step();
        check("R8", "empty after final retire", int'(empty), 1);
        check("R7", "all expected commits seen", rd, wr);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_out_of_order();
        t_flush();
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule